// File: doc/BRIEF.md
# Reset Vector Jump Injector

This block sits on the read-data path between memory and an 8-bit CPU. After every reset it forges a three-byte absolute jump instruction on the CPU's data input. The first three reads the CPU makes are answered with the opcode, a zero low address byte, and a high address byte whose upper nibble comes from a 4-bit switch. The CPU therefore starts execution at one of sixteen 4 KB-aligned addresses, from 0000h to F000h, without any change to memory contents.

Once the third forged byte has been consumed, the block becomes transparent and memory data reaches the CPU unchanged. A strap input turns the feature off, and the CPU then starts at 0000h. The read and fetch strobes are plain level signals. The block adds no latency and applies no back-pressure: the data byte is a combinational selection that is valid for as long as a strobe is high.

Top module: `jump_injector`

## Requirements
- R1: While reset is applied and during the two clock edges after its release, the forging state is re-armed. With the strap on, `inject_active` reads 1 after reset.
- R2: A read is any cycle with `mem_rd` or `fetch` high. While forging is active, the first read after reset returns C3h on `cpu_data`.
- R3: The second forged read returns 00h, which is the low byte of the target.
- R4: The third forged read returns `{jump_sel, 4'h0}`. Bit i of `jump_sel` becomes target address bit 12+i, so switch value 5 gives target 5000h and value F gives F000h.
- R5: The slot index advances only on the falling edge of the combined read strobe, sampled at the clock. The forged byte is held for the whole length of a strobe.
- R6: After the third forged read ends, `inject_active` drops and stays low until the next reset. From then on, `cpu_data` equals `mem_data`.
- R7: While forging is active, `mem_data` has no effect on `cpu_data` during a read. Outside a read, `cpu_data` equals `mem_data`.
- R8: With `jump_en` low, `inject_active` is 0 and `cpu_data` always equals `mem_data`. Execution therefore starts at 0000h.
- R9: A reset applied partway through the forged sequence restarts it at the opcode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronised inside the block |
| jump_en | input | 1 | Strap that enables the jump feature |
| jump_sel | input | 4 | Switch value giving target address bits 15:12 |
| mem_rd | input | 1 | CPU memory read strobe, active high |
| fetch | input | 1 | CPU opcode fetch strobe, active high |
| mem_data | input | 8 | Data read from memory |
| cpu_data | output | 8 | Data byte presented to the CPU |
| inject_active | output | 1 | High while forged bytes are being supplied |

## Verification
On every cycle, the in-module assertions check three things. Each forged slot carries its fixed byte value. The output passes memory data through whenever forging is inactive. The slot index moves only on a strobe's falling edge, and the active flag never re-arms outside reset. Only the bench scenarios can show the order of the whole sequence: that exactly three reads are forged, that a mid-sequence reset restarts from the opcode, and that the switch value reaches the high byte for several settings. A per-cycle reference model compares both outputs against these scenarios.

// File: rtl/jinj_pkg.sv
package jinj_pkg;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned DATA_W  = 8;
  localparam logic [DATA_W-1:0] JMP_OPCODE = 8'hC3;
  localparam logic [DATA_W-1:0] TGT_LOW    = 8'h00;

  typedef enum logic [1:0] {
    SLOT_OP = 2'd0,
    SLOT_LO = 2'd1,
    SLOT_HI = 2'd2
  } slot_t;

  function automatic logic [DATA_W-1:0] slot_byte(slot_t s, logic [SEL_W-1:0] sel);
    case (s)
      SLOT_OP: slot_byte = JMP_OPCODE;
      SLOT_LO: slot_byte = TGT_LOW;
      default: slot_byte = {sel, {(DATA_W-SEL_W){1'b0}}};
    endcase
  endfunction
endpackage

// File: rtl/jinj_rst_sync.sv
module jinj_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/jinj_seq.sv
module jinj_seq
  import jinj_pkg::*;
(
  input  logic  clk,
  input  logic  srst_n,
  input  logic  jump_en,
  input  logic  rd_any,
  output slot_t slot,
  output logic  inject
);
  logic armed;
  logic rd_q;
  logic rd_fall;

  assign rd_fall = rd_q && !rd_any;
  assign inject  = armed && jump_en;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      armed <= 1'b1;
      slot  <= SLOT_OP;
      rd_q  <= 1'b0;
    end else begin
      rd_q <= rd_any;
      if (inject && rd_fall) begin
        if (slot == SLOT_HI) begin
          armed <= 1'b0;
          slot  <= SLOT_OP;
        end else begin
          slot <= slot_t'(slot + 2'd1);
        end
      end
    end
  end

  // R6: once disarmed, the flag cannot come back without a reset
  a_r6_no_rearm: assert property (@(posedge clk) disable iff (!srst_n)
    !armed |=> !armed);

  // R5: slot index is frozen unless a strobe has just ended
  a_r5_slot_on_fall: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_any || !rd_q) |=> $stable(slot));

  // R5: the slot never reaches the unused encoding
  a_r5_slot_range: assert property (@(posedge clk) disable iff (!srst_n)
    slot != 2'd3);
endmodule

// File: rtl/jinj_mux.sv
module jinj_mux
  import jinj_pkg::*;
(
  input  logic              inject,
  input  logic              rd_any,
  input  slot_t             slot,
  input  logic [SEL_W-1:0]  jump_sel,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] cpu_data
);
  always_comb begin
    if (inject && rd_any) cpu_data = slot_byte(slot, jump_sel);
    else                  cpu_data = mem_data;
  end
endmodule

// File: rtl/jump_injector.sv
module jump_injector
  import jinj_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jump_en,
  input  logic [SEL_W-1:0]  jump_sel,
  input  logic              mem_rd,
  input  logic              fetch,
  input  logic [DATA_W-1:0] mem_data,
  output logic [DATA_W-1:0] cpu_data,
  output logic              inject_active
);
  logic  srst_n;
  logic  rd_any;
  slot_t slot;

  assign rd_any = mem_rd | fetch;

  jinj_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  jinj_seq u_seq (
    .clk     (clk),
    .srst_n  (srst_n),
    .jump_en (jump_en),
    .rd_any  (rd_any),
    .slot    (slot),
    .inject  (inject_active)
  );

  jinj_mux u_mux (
    .inject   (inject_active),
    .rd_any   (rd_any),
    .slot     (slot),
    .jump_sel (jump_sel),
    .mem_data (mem_data),
    .cpu_data (cpu_data)
  );

  // R2: the opcode slot drives C3h
  a_r2_opcode: assert property (@(posedge clk) disable iff (!srst_n)
    (inject_active && rd_any && slot == SLOT_OP) |-> cpu_data == 8'hC3);

  // R3: the low-address slot drives zero
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!srst_n)
    (inject_active && rd_any && slot == SLOT_LO) |-> cpu_data == 8'h00);

  // R4: the high slot carries the switch nibble over a zero nibble
  a_r4_high_sel: assert property (@(posedge clk) disable iff (!srst_n)
    (inject_active && rd_any && slot == SLOT_HI) |->
      (cpu_data[7:4] == jump_sel && cpu_data[3:0] == 4'h0));

  // R7: memory data passes through outside a forged read
  a_r7_passthru: assert property (@(posedge clk) disable iff (!srst_n)
    !(inject_active && rd_any) |-> cpu_data == mem_data);

  // R8: strap off keeps the flag low
  a_r8_strap_off: assert property (@(posedge clk) disable iff (!srst_n)
    !jump_en |-> !inject_active);
endmodule

// File: tb/jump_injector_bench.sv
module jump_injector_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       jump_en = 1'b1;
  logic [3:0] jump_sel = 4'h0;
  logic       mem_rd = 1'b0;
  logic       fetch = 1'b0;
  logic [7:0] mem_data = 8'h00;
  logic [7:0] cpu_data;
  logic       inject_active;

  int vectors = 0;
  int errors  = 0;

  // behavioural reference state
  bit m_armed = 1'b1;
  int m_cnt   = 0;
  bit m_rdq   = 1'b0;
  int m_sync  = 0;

  always #2 clk = ~clk;

  jump_injector u_jump_injector (
    .clk(clk), .rst_n(rst_n), .jump_en(jump_en), .jump_sel(jump_sel),
    .mem_rd(mem_rd), .fetch(fetch), .mem_data(mem_data),
    .cpu_data(cpu_data), .inject_active(inject_active)
  );

  function automatic logic [7:0] exp_data();
    bit rdn = mem_rd | fetch;
    if (m_armed && jump_en && rdn) begin
      if (m_cnt == 0) return 8'hC3;
      if (m_cnt == 1) return 8'h00;
      return {jump_sel, 4'h0};
    end
    return mem_data;
  endfunction

  function automatic string data_tag();
    bit rdn = mem_rd | fetch;
    if (!jump_en) return "R8";
    if (m_armed && rdn) begin
      if (m_cnt == 0) return "R2";
      if (m_cnt == 1) return "R3";
      return "R4";
    end
    if (!m_armed) return "R6";
    return "R7";
  endfunction

  task automatic cyc(input bit r, input bit en, input logic [3:0] s,
                     input bit rd, input bit fe, input logic [7:0] d);
    bit rdn;
    logic [7:0] ed;
    bit ef;
    @(negedge clk);
    rst_n = r; jump_en = en; jump_sel = s; mem_rd = rd; fetch = fe; mem_data = d;
    if (!r) begin m_armed = 1'b1; m_cnt = 0; m_rdq = 1'b0; m_sync = 0; end
    #1;
    ed = exp_data();
    ef = m_armed && en;
    vectors++;
    if (cpu_data !== ed) begin
      errors++;
      $display("FAIL %s cpu_data actual %h expected %h at %0t", data_tag(), cpu_data, ed, $time);
    end
    vectors++;
    if (inject_active !== ef) begin
      errors++;
      $display("FAIL %s inject_active actual %b expected %b at %0t",
               (!en ? "R8" : (m_armed ? "R1" : "R6")), inject_active, ef, $time);
    end
    @(posedge clk);
    rdn = rd | fe;
    if (!r || m_sync < 2) begin
      m_armed = 1'b1; m_cnt = 0; m_rdq = 1'b0;
    end else begin
      if (m_armed && en && m_rdq && !rdn) begin
        if (m_cnt == 2) begin m_armed = 1'b0; m_cnt = 0; end
        else m_cnt++;
      end
      m_rdq = rdn;
    end
    if (r && m_sync < 2) m_sync++;
  endtask

  // one bus read: strobe high for `len` cycles, then one idle cycle
  task automatic bus_read(input bit en, input logic [3:0] s, input bit is_fetch,
                          input int len, input logic [7:0] d);
    for (int i = 0; i < len; i++)
      cyc(1'b1, en, s, !is_fetch, is_fetch, d ^ 8'(i * 37));
    cyc(1'b1, en, s, 1'b0, 1'b0, ~d);
  endtask

  task automatic do_reset(input bit en, input logic [3:0] s);
    for (int i = 0; i < 3; i++) cyc(1'b0, en, s, 1'b0, 1'b0, 8'h5A);
    for (int i = 0; i < 3; i++) cyc(1'b1, en, s, 1'b0, 1'b0, 8'hA5);
  endtask

  initial begin
    // R1: reset state with strap on
    do_reset(1'b1, 4'h5);
    // R2 R3 R4 R5: full sequence with sel 5, fetch for the opcode, long strobes
    bus_read(1'b1, 4'h5, 1'b1, 3, 8'h11);
    bus_read(1'b1, 4'h5, 1'b0, 1, 8'h22);
    bus_read(1'b1, 4'h5, 1'b0, 4, 8'h33);
    // R6: transparent afterwards
    for (int k = 0; k < 5; k++) bus_read(1'b1, 4'h5, k[0], 2, 8'(8'h40 + k));
    // R9: reset after one forged byte restarts at the opcode
    do_reset(1'b1, 4'hF);
    bus_read(1'b1, 4'hF, 1'b1, 2, 8'h77);
    do_reset(1'b1, 4'hF);
    bus_read(1'b1, 4'hF, 1'b1, 2, 8'h78);
    bus_read(1'b1, 4'hF, 1'b0, 2, 8'h79);
    bus_read(1'b1, 4'hF, 1'b0, 2, 8'h7A);
    bus_read(1'b1, 4'hF, 1'b0, 2, 8'h7B);
    // R4: switch value 0 and a single-bit value, R7: data ignored while forging
    do_reset(1'b1, 4'h0);
    for (int k = 0; k < 4; k++) bus_read(1'b1, 4'h0, 1'b0, 1, 8'hFF);
    do_reset(1'b1, 4'h8);
    for (int k = 0; k < 4; k++) bus_read(1'b1, 4'h8, 1'b1, 2, 8'(8'h90 + k));
    // R8: strap off gives pure pass-through
    do_reset(1'b0, 4'hC);
    for (int k = 0; k < 4; k++) bus_read(1'b0, 4'hC, k[0], 2, 8'(8'hC0 + k));
    // R1: reads during the synchronised release are still forged (R5 no advance until armed run)
    for (int i = 0; i < 2; i++) cyc(1'b0, 1'b1, 4'h3, 1'b0, 1'b0, 8'h00);
    cyc(1'b1, 1'b1, 4'h3, 1'b1, 1'b0, 8'h12);
    cyc(1'b1, 1'b1, 4'h3, 1'b0, 1'b0, 8'h13);
    for (int k = 0; k < 4; k++) bus_read(1'b1, 4'h3, 1'b0, 2, 8'(8'hD0 + k));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule